// File: doc/BRIEF.md
# Fractional-Duty PWM Generator with Frame-Aligned Buffer

The block produces a fixed-period pulse-width-modulated output from an 8-bit up counter that wraps every 256 source ticks. A 12-bit duty word sets the pulse. Its upper eight bits give the whole-count pulse width. Its lower four bits give a count N of periods, out of every group of sixteen, that are stretched by one extra tick. Averaged over a 16-period frame, the duty therefore has 1/16-count resolution. The stretched periods are spread across the frame instead of being bunched together.

Software loads the duty word in two byte writes, low byte first. A buffer option decides when a new word reaches the comparator. With the buffer on and the timer running, the new word waits for the next frame boundary. Otherwise it applies at once. Readback returns the pending word when the buffer is on. The counter advances either on an internal tick enable or on rising edges of an external clock pin, which is synchronised first. A one-cycle pulse marks every counter wrap, and a second pulse marks every frame boundary.

Top module: `frac_pwm`

## Requirements
- R1: While running, the counter advances once per source tick from 0 to 255 and wraps to 0. Each period is 256 ticks long. `ovf_irq` is high for one clock in the first clock after each wrap.
- R2: `frame_irq` is high together with `ovf_irq` on every 16th wrap after run starts, and is low on every other wrap.
- R3: Each period opens at the level on `idle_level` and stays there for T ticks. The output then inverts and holds until the wrap. T is duty bits [11:4] plus the extra tick of R4. If T reaches 256, the output does not invert in that period.
- R4: Periods are numbered within the frame by a 4-bit index: 0 at run start, plus one at each wrap. A period with index f gets one extra tick when the bit-reversed f is below N = duty bits [3:0]. N=5 therefore stretches indexes 0, 8, 4, 12 and 2.
- R5: `wr_lo` stages `wdata` as duty bits [7:0], and `wr_hi` supplies duty bits [11:8] from `wdata[3:0]`. A low write alone changes neither the readback nor the active duty.
- R6: With `dbuf_en`=1 and the timer running, a completed write goes only to the buffer. The active duty takes the buffered word at the wrap that ends frame index 15, together with `frame_irq`.
- R7: `rb_duty` shows the buffered (last written) word while `dbuf_en`=1, and the active word while `dbuf_en`=0.
- R8: With `dbuf_en`=1 and `run_en`=0, a completed write updates both the buffer and the active duty at once.
- R9: With `dbuf_en`=0, a completed write takes effect at once. If the new width is below the current count, the output does not invert again before the next wrap.
- R10: While `run_en`=0, the counter and frame index are held at 0, no pulses are produced, and from the next clock the output equals `idle_level`.
- R11: With `ext_sel`=1, `ext_clk_in` passes through two synchroniser flops and a rising-edge detector. Each rising edge is one source tick, and `int_tick` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low stops and clears the counter |
| idle_level | input | 1 | Output level at the start of each period |
| dbuf_en | input | 1 | Frame-aligned buffering of duty writes |
| ext_sel | input | 1 | 1 selects the external clock pin as tick source |
| int_tick | input | 1 | Internal tick enable, one count per high clock |
| ext_clk_in | input | 1 | Asynchronous external clock |
| wr_lo | input | 1 | Strobe: stage duty low byte |
| wr_hi | input | 1 | Strobe: duty high bits, completes the write |
| wdata | input | 8 | Write data |
| rb_duty | output | 12 | Duty readback |
| pwm_out | output | 1 | PWM output |
| ovf_irq | output | 1 | One-clock pulse per counter wrap |
| frame_irq | output | 1 | One-clock pulse per 16th wrap |

## Verification
The properties assume that the external clock, once synchronised, holds each level for at least two system clocks. One property checks this directly on the synchronised level. Another assumption is that `wr_hi` is never raised without a low-byte write staged just before it. The stimulus toggles the external pin every two clocks, so each level lasts exactly at the limit. Writes always come as a low-byte strobe followed directly by a high-byte strobe, and run, buffer and polarity settings are only changed while the monitor is idle.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;

  // Reverse the lowest w bits of v.
  function automatic int unsigned bit_rev(input int unsigned v, input int unsigned w);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < w; i++) begin
      r = (r << 1) | ((v >> i) & 1);
    end
    return r;
  endfunction

  // A period at frame position f is stretched when its reversed index is below n.
  function automatic logic extra_due(input int unsigned f, input int unsigned n,
                                     input int unsigned w);
    return bit_rev(f, w) < n;
  endfunction

endpackage

// File: rtl/fpwm_tick_src.sv
module fpwm_tick_src #(
  parameter int SYNC_N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fpwm_pkg::clk_src_e  src,
  input  logic                int_tick,
  input  logic                ext_in,
  output logic                tick,
  output logic                sync_lvl,
  output logic                sync_prev
);
  logic [SYNC_N-1:0] sync_q;
  logic              ext_rise;

  generate
    for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[i] <= 1'b0;
        end else begin
          if (i == 0) sync_q[i] <= ext_in;
          else        sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_prev <= 1'b0;
    else        sync_prev <= sync_q[SYNC_N-1];
  end

  assign sync_lvl = sync_q[SYNC_N-1];
  assign ext_rise = sync_lvl & ~sync_prev;
  assign tick     = (src == fpwm_pkg::SRC_EXT) ? ext_rise : int_tick;
endmodule

// File: rtl/fpwm_duty_regs.sv
module fpwm_duty_regs #(
  parameter int BUS_W  = 8,
  parameter int DUTY_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              dbuf_en,
  input  logic              run,
  input  logic              commit,
  output logic [DUTY_W-1:0] duty_buf,
  output logic [DUTY_W-1:0] duty_act,
  output logic [DUTY_W-1:0] duty_nxt,
  output logic [DUTY_W-1:0] rb
);
  localparam int HI_W = DUTY_W - BUS_W;

  logic [BUS_W-1:0]  stage_lo;
  logic [DUTY_W-1:0] new_word;
  logic              direct;
  logic              wdata_unused;

  assign wdata_unused = ^wdata[BUS_W-1:HI_W];
  assign new_word     = {wdata[HI_W-1:0], stage_lo};
  assign direct       = !dbuf_en || !run;

  always_comb begin
    duty_nxt = duty_act;
    if (wr_hi && direct)       duty_nxt = new_word;
    else if (commit && dbuf_en) duty_nxt = duty_buf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo <= '0;
      duty_buf <= '0;
      duty_act <= '0;
    end else begin
      if (wr_lo) stage_lo <= wdata;
      if (wr_hi) duty_buf <= new_word;
      duty_act <= duty_nxt;
    end
  end

  assign rb = dbuf_en ? duty_buf : duty_act;
endmodule

// File: rtl/fpwm_core.sv
module fpwm_core #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     tick,
  input  logic [CNT_W+FRAC_W-1:0]  duty_act,
  input  logic [CNT_W+FRAC_W-1:0]  duty_nxt,
  output logic [CNT_W-1:0]         cnt,
  output logic [FRAC_W-1:0]        frame_idx,
  output logic                     inv,
  output logic [CNT_W:0]           thresh,
  output logic                     commit,
  output logic                     ovf_pulse,
  output logic                     frame_pulse
);
  localparam int DUTY_W = CNT_W + FRAC_W;
  localparam int TW     = CNT_W + 1;
  localparam logic [CNT_W-1:0]  CMAX = '1;
  localparam logic [FRAC_W-1:0] FMAX = '1;

  // Ticks at the start level for a given duty word and frame position.
  function automatic logic [TW-1:0] thresh_of(input logic [DUTY_W-1:0] d,
                                              input logic [FRAC_W-1:0] f);
    logic ex;
    ex = fpwm_pkg::extra_due(int'(f), int'(d[FRAC_W-1:0]), FRAC_W);
    return {1'b0, d[DUTY_W-1:FRAC_W]} + TW'(ex);
  endfunction

  logic            wrap;
  logic [CNT_W-1:0] cnt_n;
  logic [TW-1:0]   thresh_new;

  assign wrap       = run && tick && (cnt == CMAX);
  assign commit     = wrap && (frame_idx == FMAX);
  assign cnt_n      = cnt + CNT_W'(1);
  assign thresh     = thresh_of(duty_act, frame_idx);
  assign thresh_new = thresh_of(duty_nxt, frame_idx + FRAC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      frame_idx   <= '0;
      inv         <= 1'b0;
      ovf_pulse   <= 1'b0;
      frame_pulse <= 1'b0;
    end else if (!run) begin
      cnt         <= '0;
      frame_idx   <= '0;
      inv         <= 1'b0;
      ovf_pulse   <= 1'b0;
      frame_pulse <= 1'b0;
    end else begin
      ovf_pulse   <= wrap;
      frame_pulse <= commit;
      if (tick) begin
        cnt <= cnt_n;
        if (wrap) begin
          frame_idx <= frame_idx + FRAC_W'(1);
          inv       <= (thresh_new == '0);
        end else if ({1'b0, cnt_n} == thresh) begin
          inv <= 1'b1;
        end
      end else if ({1'b0, cnt} == thresh) begin
        inv <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frac_pwm.sv
module frac_pwm #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int BUS_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_en,
  input  logic                     idle_level,
  input  logic                     dbuf_en,
  input  logic                     ext_sel,
  input  logic                     int_tick,
  input  logic                     ext_clk_in,
  input  logic                     wr_lo,
  input  logic                     wr_hi,
  input  logic [BUS_W-1:0]         wdata,
  output logic [CNT_W+FRAC_W-1:0]  rb_duty,
  output logic                     pwm_out,
  output logic                     ovf_irq,
  output logic                     frame_irq
);
  localparam int DUTY_W = CNT_W + FRAC_W;

  fpwm_pkg::clk_src_e src;
  logic               tick;
  logic               sync_lvl;
  logic               sync_prev;
  logic [DUTY_W-1:0]  duty_buf;
  logic [DUTY_W-1:0]  duty_act;
  logic [DUTY_W-1:0]  duty_nxt;
  logic [CNT_W-1:0]   cnt;
  logic [FRAC_W-1:0]  frame_idx;
  logic               inv;
  logic [CNT_W:0]     thresh;
  logic               commit;

  assign src = ext_sel ? fpwm_pkg::SRC_EXT : fpwm_pkg::SRC_INT;

  fpwm_tick_src #(.SYNC_N(SYNC_N)) u_tick (
    .clk(clk), .rst_n(rst_n), .src(src), .int_tick(int_tick), .ext_in(ext_clk_in),
    .tick(tick), .sync_lvl(sync_lvl), .sync_prev(sync_prev)
  );

  fpwm_duty_regs #(.BUS_W(BUS_W), .DUTY_W(DUTY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
    .dbuf_en(dbuf_en), .run(run_en), .commit(commit),
    .duty_buf(duty_buf), .duty_act(duty_act), .duty_nxt(duty_nxt), .rb(rb_duty)
  );

  fpwm_core #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick),
    .duty_act(duty_act), .duty_nxt(duty_nxt),
    .cnt(cnt), .frame_idx(frame_idx), .inv(inv), .thresh(thresh), .commit(commit),
    .ovf_pulse(ovf_irq), .frame_pulse(frame_irq)
  );

  assign pwm_out = idle_level ^ inv;
endmodule

// File: rtl/fpwm_chk.sv
module fpwm_chk #(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run_en,
  input logic                    idle_level,
  input logic                    dbuf_en,
  input logic                    ext_sel,
  input logic                    wr_hi,
  input logic                    tick,
  input logic                    sync_lvl,
  input logic                    sync_prev,
  input logic [CNT_W-1:0]        cnt,
  input logic                    inv,
  input logic [CNT_W:0]          thresh,
  input logic                    commit,
  input logic [CNT_W+FRAC_W-1:0] duty_act,
  input logic [CNT_W+FRAC_W-1:0] duty_buf,
  input logic                    pwm_out,
  input logic                    ovf_irq,
  input logic                    frame_irq
);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && tick && (cnt == '1) |=> ovf_irq && (cnt == '0));

  a_r2_frame_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> frame_irq);

  a_r2_frame_with_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> ovf_irq);

  a_r3_revert_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (!inv || (thresh == '0)));

  a_r6_hold_until_frame: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_en && run_en && !commit |=> $stable(duty_act));

  a_r9_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    !dbuf_en && wr_hi |=> (duty_act == duty_buf));

  a_r10_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pwm_out == idle_level) && (cnt == '0) && !ovf_irq && !frame_irq);

  a_r11_ext_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel && (sync_lvl != sync_prev) |=> (sync_lvl == sync_prev));
endmodule

bind frac_pwm fpwm_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .idle_level(idle_level),
  .dbuf_en(dbuf_en), .ext_sel(ext_sel), .wr_hi(wr_hi), .tick(tick),
  .sync_lvl(sync_lvl), .sync_prev(sync_prev), .cnt(cnt), .inv(inv),
  .thresh(thresh), .commit(commit), .duty_act(duty_act), .duty_buf(duty_buf),
  .pwm_out(pwm_out), .ovf_irq(ovf_irq), .frame_irq(frame_irq)
);

// File: tb/sim_frac_pwm.sv
module sim_frac_pwm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        idle_level = 1'b0;
  logic        dbuf_en = 1'b0;
  logic        ext_sel = 1'b0;
  logic        int_tick = 1'b1;
  logic        ext_clk_in = 1'b0;
  logic        wr_lo = 1'b0;
  logic        wr_hi = 1'b0;
  logic [7:0]  wdata = '0;
  logic [11:0] rb_duty;
  logic        pwm_out;
  logic        ovf_irq;
  logic        frame_irq;

  frac_pwm u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .idle_level(idle_level),
    .dbuf_en(dbuf_en), .ext_sel(ext_sel), .int_tick(int_tick), .ext_clk_in(ext_clk_in),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata), .rb_duty(rb_duty),
    .pwm_out(pwm_out), .ovf_irq(ovf_irq), .frame_irq(frame_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  bit mon_on = 0;
  bit armed = 0;
  bit ext_on = 0;
  int ovf_cnt = 0;
  int tpp = 1;
  int idle_cnt = 0;
  int per_cnt = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected clocks at the start level for period p of a run.
  function automatic int exp_width(input int duty, input int p, input int ticks);
    int f, rv, hi, n;
    f  = p % 16;
    hi = duty / 16;
    n  = duty % 16;
    rv = ((f & 1) * 8) + ((f & 2) * 2) + ((f & 4) / 2) + ((f & 8) / 8);
    return ticks * (hi + ((rv < n) ? 1 : 0));
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_lo(input int v);
    step(); wr_lo = 1'b1; wdata = v[7:0];
    step(); wr_lo = 1'b0;
  endtask

  task automatic write_duty(input int v);
    step(); wr_lo = 1'b1; wdata = v[7:0];
    step(); wr_lo = 1'b0; wr_hi = 1'b1; wdata = {4'h0, v[11:8]};
    step(); wr_hi = 1'b0; wdata = '0;
  endtask

  task automatic push_periods(input int duty, input int p0, input int p1);
    for (int p = p0; p <= p1; p++) exp_q.push_back(exp_width(duty, p, tpp));
  endtask

  task automatic start_run();
    ovf_cnt = 0; armed = 0; mon_on = 1'b1;
    run_en = 1'b1;
  endtask

  task automatic drain_and_stop();
    while (exp_q.size() != 0) step();
    mon_on = 1'b0;
    run_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(pwm_out == idle_level, "R10 stop level", pwm_out, idle_level);
    repeat (300) begin
      @(negedge clk);
      if (ovf_irq || frame_irq) check(0, "R10 pulse while stopped", 1, 0);
    end
    n_chk++;
  endtask

  // External clock: each level held for two clocks.
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (ext_on) begin
        ph++;
        if (ph == 2) begin ext_clk_in = ~ext_clk_in; ph = 0; end
      end
    end
  end

  // Monitor: measures each period between wrap pulses and scores it.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mon_on) begin
        if (ovf_irq) begin
          ovf_cnt++;
          check(frame_irq == ((ovf_cnt % 16) == 0), "R2 frame pulse", frame_irq,
                (ovf_cnt % 16) == 0);
          if (armed) begin
            check(per_cnt == 256 * tpp, "R1 period length", per_cnt, 256 * tpp);
            if (exp_q.size() != 0) begin
              int e;
              e = exp_q.pop_front();
              check(idle_cnt == e, "R3/R4 start-level width", idle_cnt, e);
            end
          end
          armed = (exp_q.size() != 0);
          idle_cnt = 0; per_cnt = 0;
        end
        if (armed) begin
          per_cnt++;
          if (pwm_out == idle_level) idle_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(pwm_out == 1'b0, "R10 reset output", pwm_out, 0);
    check(ovf_irq == 1'b0 && frame_irq == 1'b0, "R10 reset pulses", ovf_irq, 0);
    check(rb_duty == 12'h000, "R7 reset readback", rb_duty, 0);

    // Phase 1: direct writes, spread extra ticks, N=5
    write_lo(8'h05);
    @(negedge clk);
    check(rb_duty == 12'h000, "R5 low byte alone", rb_duty, 0);
    write_duty(12'h805);
    @(negedge clk);
    check(rb_duty == 12'h805, "R5 completed write", rb_duty, 12'h805);
    tpp = 1;
    push_periods(12'h805, 1, 20);
    start_run();
    drain_and_stop();

    // Phase 2: buffered, inverted polarity, stopped write then mid-frame write
    idle_level = 1'b1; dbuf_en = 1'b1;
    write_duty(12'h3A3);
    @(negedge clk);
    check(rb_duty == 12'h3A3, "R8 stopped buffered write", rb_duty, 12'h3A3);
    check(pwm_out == 1'b1, "R3 polarity while stopped", pwm_out, 1);
    push_periods(12'h3A3, 1, 31);
    push_periods(12'h6CF, 32, 40);
    start_run();
    while (ovf_cnt < 20) step();
    write_duty(12'h6CF);
    @(negedge clk);
    check(rb_duty == 12'h6CF, "R7 buffered readback", rb_duty, 12'h6CF);
    drain_and_stop();

    // Phase 3: direct write while running, below current count (R9)
    idle_level = 1'b0; dbuf_en = 1'b0;
    write_duty(12'hF00);
    exp_q.push_back(exp_width(12'hF00, 1, 1));
    exp_q.push_back(exp_width(12'hF00, 2, 1));
    exp_q.push_back(256);
    exp_q.push_back(exp_width(12'h200, 4, 1));
    exp_q.push_back(exp_width(12'h200, 5, 1));
    start_run();
    while (ovf_cnt < 3) step();
    repeat (128) step();
    write_duty(12'h200);
    @(negedge clk);
    check(rb_duty == 12'h200, "R7 active readback", rb_duty, 12'h200);
    drain_and_stop();

    // Phase 4: external clock source, int_tick ignored (R11)
    write_duty(12'h404);
    int_tick = 1'b0; ext_sel = 1'b1; ext_on = 1'b1;
    repeat (8) step();
    tpp = 4;
    push_periods(12'h404, 1, 3);
    start_run();
    drain_and_stop();
    int_tick = 1'b1;
    repeat (20) step();
    @(negedge clk);
    check(ovf_irq == 1'b0, "R11 stopped under int_tick", ovf_irq, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule